// File: doc/BRIEF.md
# I2C Multi-Payload Transaction Sequencer

This block runs one I2C command made of up to `N_PAY` payloads on top of a byte-level bus engine. Each payload is described by a 7-bit target address, a direction flag and a byte count, all held in a small descriptor table. The bytes themselves live in a shared data buffer. Payloads consume or fill that buffer from index 0 upward, in payload order. For every payload the sequencer asks the engine for a start condition, then the address byte, then the data bytes. Every payload except the first therefore begins with a repeated start.

A stop condition goes out only after the final payload, or straight after any failed step. Payloads that are not last are chained to the next one without releasing the bus. The first failure abandons the rest of the command and the command reports failure. When a command starts, its bus speed is turned into a bit-period value and loaded into the engine's timing output before the first engine request.

The engine is driven with a one-cycle request pulse carrying an operation code, and it answers with a one-cycle done pulse and a success flag. The command status stays unchanged until the next accepted start.

Top module: `i2c_txn_seq`

## Requirements
- R1: After reset `busy`, `done`, `success` and `eng_req` are 0, and `eng_period` holds the default-speed value 20.
- R2: On an accepted `cmd_start`, `eng_period` takes floor(1000 / speed), raised to 12 if the quotient is smaller. A speed of 0 uses the default speed of 50, giving 20. The value is visible in the cycle after `cmd_start`, before any engine request.
- R3: Engine operation codes are 0 start, 1 stop, 2 write byte, 3 read byte. Every payload begins with a start request. The next request is a write whose byte is the address shifted left by one, with bit 0 set to 1 for a read and 0 for a write.
- R4: A write payload writes its `len` bytes from consecutive buffer entries. A write that comes back not acknowledged (`eng_ok`=0) ends the payload, is followed by a stop, and fails the command.
- R5: A read payload issues `len` read requests with `eng_more`=1 on all but the last, which has `eng_more`=0. Each returned byte is stored at the next buffer index.
- R6: No stop is requested between payloads. Exactly one stop follows the final payload, and a fully acknowledged command ends with `success`=1.
- R7: If a start request fails, no bytes are requested for that payload, a stop follows, later payloads are skipped, and `success`=0.
- R8: A stop that reports failure makes the command end with `success`=0 even when every earlier step succeeded.
- R9: A payload with length 0 sends only its start and address byte.
- R10: A command with a payload count of 0 issues no engine request and reports `done`=1, `success`=1 one cycle after `cmd_start`.
- R11: `done` and `success` hold until the next accepted start. A `cmd_start` while `busy` is ignored and does not disturb the running command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start a command (accepted only while idle) |
| cmd_count | input | CNT_W | Number of payloads in the command |
| cmd_speed | input | SPEED_W | Bus speed; 0 picks the default |
| desc_we | input | 1 | Descriptor table write strobe |
| desc_idx | input | IDX_W | Descriptor slot written |
| desc_addr | input | 7 | Target address for the slot |
| desc_rd | input | 1 | 1 = read payload, 0 = write payload |
| desc_len | input | LEN_W | Data byte count for the slot |
| buf_we | input | 1 | Data buffer write strobe (ignored while busy) |
| buf_waddr | input | PTR_W | Data buffer write index |
| buf_wdata | input | 8 | Data buffer write byte |
| buf_raddr | input | PTR_W | Data buffer read index |
| buf_rdata | output | 8 | Data buffer byte at `buf_raddr` |
| busy | output | 1 | Command in progress |
| done | output | 1 | Last command finished |
| success | output | 1 | Last command succeeded |
| eng_period | output | PERIOD_W | Bit-period value for the engine |
| eng_req | output | 1 | One-cycle engine request |
| eng_op | output | 2 | Requested operation |
| eng_wdata | output | 8 | Byte for a write request |
| eng_more | output | 1 | Read request: 1 = acknowledge, 0 = not acknowledge |
| eng_done | input | 1 | Engine finished the request |
| eng_ok | input | 1 | Engine request succeeded / byte acknowledged |
| eng_rdata | input | 8 | Byte returned by a read request |

## Verification
The bench targets chaining first: a design that put a stop after every payload, or left it out after the last, emits an unexpected stop request or misses the expected one. Failures are injected on a data byte, on a repeated start in the middle of a command and on the final stop. A design that kept going after a failure would issue requests the model does not expect, and one that ignored a failed stop would report success. The read acknowledge pattern, zero-length and zero-count cases, the speed floor and default, and a start pulse issued mid-command are all exercised. A wrong pointer, a misplaced read-bit, or a restart on a stray pulse each shows up in the request stream or in the buffer readback.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } eng_op_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_ADDR  = 3'd2,
        ST_DATA  = 3'd3,
        ST_STOP  = 3'd4
    } seq_state_t;

endpackage

// File: rtl/i2cseq_rate.sv
// Converts a speed setting into the engine bit-period value.
module i2cseq_rate #(
    parameter int SPEED_W    = 16,
    parameter int PERIOD_W   = 16,
    parameter int NUMERATOR  = 1000,
    parameter int DEF_SPEED  = 50,
    parameter int MIN_PERIOD = 12
) (
    input  logic [SPEED_W-1:0]  speed,
    output logic [PERIOD_W-1:0] period
);
    logic [SPEED_W-1:0]  eff_speed;
    logic [PERIOD_W-1:0] quot;

    always_comb begin
        eff_speed = (speed == '0) ? SPEED_W'(DEF_SPEED) : speed;
        quot      = PERIOD_W'(NUMERATOR / int'(eff_speed));
        period    = (quot < PERIOD_W'(MIN_PERIOD)) ? PERIOD_W'(MIN_PERIOD) : quot;
    end
endmodule

// File: rtl/i2cseq_desc.sv
// Payload descriptor table: address, direction and length per slot.
module i2cseq_desc #(
    parameter int N_PAY = 4,
    parameter int LEN_W = 4,
    localparam int IDX_W = (N_PAY > 1) ? $clog2(N_PAY) : 1,
    localparam int ENT_W = 7 + 1 + LEN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [6:0]       waddr7,
    input  logic             wrd,
    input  logic [LEN_W-1:0] wlen,
    input  logic [IDX_W-1:0] ridx,
    output logic [6:0]       raddr7,
    output logic             rrd,
    output logic [LEN_W-1:0] rlen
);
    logic [ENT_W-1:0] tbl_q [N_PAY];

    for (genvar g = 0; g < N_PAY; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                tbl_q[g] <= '0;
            else if (we && (widx == IDX_W'(g)))
                tbl_q[g] <= {waddr7, wrd, wlen};
        end
    end

    assign {raddr7, rrd, rlen} = tbl_q[ridx];
endmodule

// File: rtl/i2cseq_buf.sv
// Shared byte buffer: host port when idle, sequencer port while busy.
module i2cseq_buf #(
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             busy,
    input  logic             host_we,
    input  logic [PTR_W-1:0] host_waddr,
    input  logic [7:0]       host_wdata,
    input  logic [PTR_W-1:0] host_raddr,
    output logic [7:0]       host_rdata,
    input  logic             seq_we,
    input  logic [PTR_W-1:0] seq_addr,
    input  logic [7:0]       seq_wdata,
    output logic [7:0]       seq_rdata
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (busy) begin
            if (seq_we)
                mem_q[seq_addr] <= seq_wdata;
        end else if (host_we) begin
            mem_q[host_waddr] <= host_wdata;
        end
    end

    assign host_rdata = mem_q[host_raddr];
    assign seq_rdata  = mem_q[seq_addr];
endmodule

// File: rtl/i2c_txn_seq.sv
module i2c_txn_seq
    import i2cseq_pkg::*;
#(
    parameter int N_PAY      = 4,
    parameter int DEPTH      = 16,
    parameter int MAX_LEN    = 8,
    parameter int SPEED_W    = 16,
    parameter int PERIOD_W   = 16,
    parameter int DEF_SPEED  = 50,
    parameter int MIN_PERIOD = 12,
    localparam int NUMERATOR  = 1000,
    localparam int IDX_W      = (N_PAY > 1) ? $clog2(N_PAY) : 1,
    localparam int CNT_W      = $clog2(N_PAY + 1),
    localparam int PTR_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LEN_W      = $clog2(MAX_LEN + 1),
    localparam int RAW_RST    = NUMERATOR / DEF_SPEED,
    localparam int RST_PERIOD = (RAW_RST < MIN_PERIOD) ? MIN_PERIOD : RAW_RST
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_start,
    input  logic [CNT_W-1:0]    cmd_count,
    input  logic [SPEED_W-1:0]  cmd_speed,
    input  logic                desc_we,
    input  logic [IDX_W-1:0]    desc_idx,
    input  logic [6:0]          desc_addr,
    input  logic                desc_rd,
    input  logic [LEN_W-1:0]    desc_len,
    input  logic                buf_we,
    input  logic [PTR_W-1:0]    buf_waddr,
    input  logic [7:0]          buf_wdata,
    input  logic [PTR_W-1:0]    buf_raddr,
    output logic [7:0]          buf_rdata,
    output logic                busy,
    output logic                done,
    output logic                success,
    output logic [PERIOD_W-1:0] eng_period,
    output logic                eng_req,
    output logic [1:0]          eng_op,
    output logic [7:0]          eng_wdata,
    output logic                eng_more,
    input  logic                eng_done,
    input  logic                eng_ok,
    input  logic [7:0]          eng_rdata
);

    typedef struct packed {
        seq_state_t          st;
        logic                wt;
        logic [IDX_W-1:0]    idx;
        logic [CNT_W-1:0]    npay;
        logic [LEN_W-1:0]    cnt;
        logic [PTR_W-1:0]    ptr;
        logic                fail;
        logic                busy;
        logic                done;
        logic                ok;
        logic [PERIOD_W-1:0] period;
        logic                req;
        eng_op_t             op;
        logic [7:0]          wdata;
        logic                more;
    } regs_t;

    regs_t r_q, r_d;

    logic [PERIOD_W-1:0] new_period;
    logic [6:0]          d_addr;
    logic                d_rd;
    logic [LEN_W-1:0]    d_len;
    logic [7:0]          seq_rdata;
    logic                seq_we;
    logic                pay_end;
    logic                last_pay;
    logic                last_byte;

    i2cseq_rate #(
        .SPEED_W(SPEED_W), .PERIOD_W(PERIOD_W), .NUMERATOR(NUMERATOR),
        .DEF_SPEED(DEF_SPEED), .MIN_PERIOD(MIN_PERIOD)
    ) u_rate (
        .speed (cmd_speed),
        .period(new_period)
    );

    i2cseq_desc #(.N_PAY(N_PAY), .LEN_W(LEN_W)) u_desc (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (desc_we),
        .widx  (desc_idx),
        .waddr7(desc_addr),
        .wrd   (desc_rd),
        .wlen  (desc_len),
        .ridx  (r_q.idx),
        .raddr7(d_addr),
        .rrd   (d_rd),
        .rlen  (d_len)
    );

    i2cseq_buf #(.DEPTH(DEPTH)) u_buf (
        .clk       (clk),
        .busy      (r_q.busy),
        .host_we   (buf_we),
        .host_waddr(buf_waddr),
        .host_wdata(buf_wdata),
        .host_raddr(buf_raddr),
        .host_rdata(buf_rdata),
        .seq_we    (seq_we),
        .seq_addr  (r_q.ptr),
        .seq_wdata (eng_rdata),
        .seq_rdata (seq_rdata)
    );

    assign last_pay  = ({1'b0, r_q.idx} == CNT_W'(r_q.npay - 1'b1));
    assign last_byte = (r_q.cnt == LEN_W'(d_len - 1'b1));

    always_comb begin
        r_d     = r_q;
        r_d.req = 1'b0;
        seq_we  = 1'b0;
        pay_end = 1'b0;

        if (r_q.st == ST_IDLE) begin
            if (cmd_start) begin
                r_d.period = new_period;
                r_d.npay   = cmd_count;
                r_d.idx    = '0;
                r_d.ptr    = '0;
                r_d.cnt    = '0;
                r_d.fail   = 1'b0;
                r_d.wt     = 1'b0;
                if (cmd_count == '0) begin
                    r_d.done = 1'b1;
                    r_d.ok   = 1'b1;
                end else begin
                    r_d.done = 1'b0;
                    r_d.ok   = 1'b0;
                    r_d.busy = 1'b1;
                    r_d.st   = ST_START;
                end
            end
        end else if (!r_q.wt) begin
            // issue one request for the current step
            r_d.req = 1'b1;
            r_d.wt  = 1'b1;
            case (r_q.st)
                ST_START: r_d.op = OP_START;
                ST_ADDR: begin
                    r_d.op    = OP_WRITE;
                    r_d.wdata = {d_addr, d_rd};
                end
                ST_DATA: begin
                    r_d.op    = d_rd ? OP_READ : OP_WRITE;
                    r_d.wdata = seq_rdata;
                    r_d.more  = !last_byte;
                end
                default: r_d.op = OP_STOP;
            endcase
        end else if (eng_done) begin
            r_d.wt = 1'b0;
            case (r_q.st)
                ST_START: begin
                    if (eng_ok) r_d.st = ST_ADDR;
                    else begin r_d.fail = 1'b1; r_d.st = ST_STOP; end
                end
                ST_ADDR: begin
                    if (!eng_ok) begin
                        r_d.fail = 1'b1;
                        r_d.st   = ST_STOP;
                    end else if (d_len == '0) begin
                        pay_end = 1'b1;
                    end else begin
                        r_d.cnt = '0;
                        r_d.st  = ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (!eng_ok) begin
                        r_d.fail = 1'b1;
                        r_d.st   = ST_STOP;
                    end else begin
                        seq_we  = d_rd;
                        r_d.ptr = r_q.ptr + 1'b1;
                        r_d.cnt = r_q.cnt + 1'b1;
                        pay_end = last_byte;
                    end
                end
                default: begin
                    r_d.st   = ST_IDLE;
                    r_d.busy = 1'b0;
                    r_d.done = 1'b1;
                    r_d.ok   = !r_q.fail && eng_ok;
                end
            endcase
            if (pay_end) begin
                if (last_pay) begin
                    r_d.st = ST_STOP;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                    r_d.st  = ST_START;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= ST_IDLE;
            r_q.op     <= OP_START;
            r_q.period <= PERIOD_W'(RST_PERIOD);
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = r_q.busy;
    assign done       = r_q.done;
    assign success    = r_q.ok;
    assign eng_period = r_q.period;
    assign eng_req    = r_q.req;
    assign eng_op     = r_q.op;
    assign eng_wdata  = r_q.wdata;
    assign eng_more   = r_q.more;

endmodule

// File: rtl/i2cseq_chk.sv
module i2cseq_chk #(
    parameter int PERIOD_W   = 16,
    parameter int MIN_PERIOD = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                busy,
    input logic                done,
    input logic                eng_req,
    input logic [1:0]          eng_op,
    input logic                eng_done,
    input logic [PERIOD_W-1:0] eng_period
);
    // R10, R11: requests only inside a running command
    a_r10_req_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> busy);

    // R3: request is a single-cycle pulse
    a_r3_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |=> !eng_req);

    // R11: running and finished never at once
    a_r11_status_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R2: period never below the floor
    a_r2_period_floor: assert property (@(posedge clk) disable iff (!rst_n)
        eng_period >= PERIOD_W'(MIN_PERIOD));

    // R3: first request of a command is a start
    a_r3_first_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> (eng_req && eng_op == 2'd0));

    // R6, R8: a completed stop ends the command
    a_r6_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !eng_req && eng_done && eng_op == 2'd1) |=> (done && !busy));
endmodule

bind i2c_txn_seq i2cseq_chk #(.PERIOD_W(PERIOD_W), .MIN_PERIOD(MIN_PERIOD)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .eng_req   (eng_req),
    .eng_op    (eng_op),
    .eng_done  (eng_done),
    .eng_period(eng_period)
);

// File: tb/sim_i2c_txn_seq.sv
`timescale 1ns/1ps
module sim_i2c_txn_seq;
    localparam int OPS = 0, OPP = 1, OPW = 2, OPR = 3;

    logic clk = 0;
    logic rst_n = 0;
    logic cmd_start = 0;
    logic [2:0] cmd_count = 0;
    logic [15:0] cmd_speed = 0;
    logic desc_we = 0;
    logic [1:0] desc_idx = 0;
    logic [6:0] desc_addr = 0;
    logic desc_rd = 0;
    logic [3:0] desc_len = 0;
    logic buf_we = 0;
    logic [3:0] buf_waddr = 0;
    logic [7:0] buf_wdata = 0;
    logic [3:0] buf_raddr = 0;
    logic [7:0] buf_rdata;
    logic busy, done, success;
    logic [15:0] eng_period;
    logic eng_req;
    logic [1:0] eng_op;
    logic [7:0] eng_wdata;
    logic eng_more;
    logic eng_done = 0;
    logic eng_ok = 0;
    logic [7:0] eng_rdata = 0;

    always #2 clk = ~clk;

    i2c_txn_seq u0 (.*);

    int n_cmp = 0, n_bad = 0, cyc = 0;
    int fail_at = -1;
    bit fail_stop = 0;
    int kreq = 0, lat = 0;
    bit last_fail = 0;
    int q_op[$], q_val[$];
    logic [7:0] bmem [16];
    logic [6:0] m_addr [4];
    bit m_rd [4];
    int m_len [4];

    task automatic chk(input bit good, input string rq, input int act, input int exp);
        n_cmp++;
        if (!good) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Behavioural engine plus per-clock comparison against the expected request stream.
    always @(negedge clk) begin
        eng_done = 0;
        if (lat > 0) begin
            lat--;
            if (lat == 0) begin
                eng_done  = 1;
                eng_ok    = !last_fail;
                eng_rdata = 8'h40 + 8'(kreq - 1);
            end
        end
        if (eng_req) begin
            if (q_op.size() == 0) begin
                chk(0, "R6 unexpected request", eng_op, -1);
            end else begin
                int eo, ev;
                eo = q_op.pop_front();
                ev = q_val.pop_front();
                chk(eng_op == 2'(eo), "R3 request op", eng_op, eo);
                if (eo == OPW) chk(eng_wdata == 8'(ev), "R4 write byte", eng_wdata, ev);
                if (eo == OPR) chk(eng_more == ev[0], "R5 ack request", eng_more, ev);
            end
            last_fail = (kreq == fail_at) || (fail_stop && eng_op == 2'(OPP));
            kreq++;
            lat = 2;
        end
        if (!busy) chk(!eng_req, "R10 idle request", eng_req, 0);
    end

    task automatic load_desc(input int i, input int a, input bit rd, input int len);
        @(negedge clk);
        desc_we = 1; desc_idx = 2'(i); desc_addr = 7'(a); desc_rd = rd; desc_len = 4'(len);
        m_addr[i] = 7'(a); m_rd[i] = rd; m_len[i] = len;
        @(negedge clk);
        desc_we = 0;
    endtask

    function automatic int exp_period(input int s);
        int q;
        if (s == 0) s = 50;
        q = 1000 / s;
        return (q < 12) ? 12 : q;
    endfunction

    // Reference model: builds the expected request stream and final buffer image.
    function automatic bit build(input int count);
        int k = 0, p = 0;
        bit ok = 1;
        for (int i = 0; i < count && ok; i++) begin
            q_op.push_back(OPS); q_val.push_back(0);
            if (k == fail_at) ok = 0;
            k++;
            if (ok) begin
                q_op.push_back(OPW); q_val.push_back({m_addr[i], m_rd[i]});
                if (k == fail_at) ok = 0;
                k++;
            end
            for (int b = 0; b < m_len[i] && ok; b++) begin
                if (m_rd[i]) begin
                    q_op.push_back(OPR); q_val.push_back(b != m_len[i] - 1);
                end else begin
                    q_op.push_back(OPW); q_val.push_back(bmem[p]);
                end
                if (k == fail_at) ok = 0;
                else if (m_rd[i]) bmem[p] = 8'h40 + 8'(k);
                k++;
                p++;
            end
        end
        if (count > 0) begin
            q_op.push_back(OPP); q_val.push_back(0);
            if (fail_stop) ok = 0;
        end
        return ok;
    endfunction

    task automatic run_cmd(input int count, input int spd, input int f_at, input bit f_stop,
                           input bit poke, input string tag);
        bit exp_ok;
        fail_at = f_at; fail_stop = f_stop; kreq = 0;
        exp_ok = build(count);
        @(negedge clk);
        cmd_count = 3'(count); cmd_speed = 16'(spd); cmd_start = 1;
        @(negedge clk);
        cmd_start = 0;
        chk(eng_period == 16'(exp_period(spd)), {tag, " R2 period"}, eng_period, exp_period(spd));
        if (poke) begin
            repeat (3) @(negedge clk);
            cmd_count = 3'd1; cmd_start = 1;
            @(negedge clk);
            cmd_start = 0;
            chk(busy, {tag, " R11 start while busy"}, busy, 1);
        end
        while (!done) @(negedge clk);
        chk(success == exp_ok, {tag, " success"}, success, exp_ok);
        chk(q_op.size() == 0, {tag, " R6 requests left"}, q_op.size(), 0);
        repeat (5) @(negedge clk);
        chk(done && success == exp_ok, {tag, " R11 status held"}, {done, success}, {1'b1, exp_ok});
        for (int a = 0; a < 16; a++) begin
            buf_raddr = 4'(a);
            #0.1;
            chk(buf_rdata == bmem[a], {tag, " R5 buffer"}, buf_rdata, bmem[a]);
        end
        q_op.delete(); q_val.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !success && !eng_req, "R1 reset status", {busy, done, success, eng_req}, 0);
        chk(eng_period == 16'd20, "R1 reset period", eng_period, 20);
        rst_n = 1;
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            buf_we = 1; buf_waddr = 4'(a); buf_wdata = 8'(8'h11 * a + 3); bmem[a] = 8'(8'h11 * a + 3);
        end
        @(negedge clk);
        buf_we = 0;

        // single write payload, floor speed
        load_desc(0, 7'h50, 0, 3);
        run_cmd(1, 100, -1, 0, 0, "R4 write");
        // write then read chained, default speed, stray start
        load_desc(0, 7'h2A, 0, 1);
        load_desc(1, 7'h2A, 1, 3);
        run_cmd(2, 0, -1, 0, 1, "R6 chain");
        // NACK on second data byte of first payload
        load_desc(0, 7'h10, 0, 3);
        load_desc(1, 7'h11, 1, 2);
        load_desc(2, 7'h12, 0, 1);
        run_cmd(3, 40, 3, 0, 0, "R4 nack");
        // repeated start fails on the second payload
        load_desc(0, 7'h33, 1, 2);
        run_cmd(3, 400, 4, 0, 0, "R7 start fail");
        // stop reports failure
        load_desc(0, 7'h05, 0, 2);
        run_cmd(1, 7, -1, 1, 0, "R8 stop fail");
        // zero-length payloads chained to a read
        load_desc(0, 7'h77, 0, 0);
        load_desc(1, 7'h78, 1, 0);
        load_desc(2, 7'h79, 1, 1);
        run_cmd(3, 25, -1, 0, 0, "R9 zero length");
        // empty command
        run_cmd(0, 90, -1, 0, 0, "R10 empty");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule